// File: doc/BRIEF.md
# Best-Offset Prefetch Learning Engine

This block watches the stream of demand accesses reaching a cache and learns which single line offset, added to a demand line, would most often have fetched a line shortly before it was needed. It keeps a fixed, ascending list of candidate offsets. These are the integers whose only prime factors are 2, 3 and 5, and optionally each one is paired with its negative. Every accepted access tests one candidate. The engine asks an external recent-requests store whether the line `tag - offset` was seen lately. A hit adds one to that candidate's score.

Candidates are visited round-robin, and a full pass over the list is a round. A learning phase closes at the end of a round in either of two cases: some score has reached a maximum, or the number of rounds has reached a maximum. The phase winner then becomes the active offset and prefetching is switched on. When a round closes with a poor best score and no phase end, prefetching is switched off. Each access yields at most one prefetch, to the access address plus the active offset times the line size.

The engine is a four-state machine. IDLE accepts an access. LOOKUP drives the request. WAIT holds off new accesses until the hit answer arrives. EMIT presents the prefetch result. The transitions are: IDLE→LOOKUP on an accepted access, LOOKUP→WAIT always, WAIT→EMIT on the response, and EMIT→IDLE always.

Top module: `offset_learn_engine`

## Requirements
- R1: The candidate list holds the positive integers with no prime factor other than 2, 3 and 5, ascending from 1 (1, 2, 3, 4, 5, 6, 8, ...). With negative offsets enabled, entry 2k is the (k+1)-th such integer and entry 2k+1 is its negation (1, -1, 2, -2, ...).
- R2: The line tag is the access address shifted right by LINE_BITS and truncated to TAG_W bits. The lookup tag is (tag - candidate) modulo 2^TAG_W, and the candidate is the one at the current list pointer.
- R3: `acc_ready` is high only in IDLE. Each accepted access produces exactly one single-cycle `rr_req_valid` in the next cycle. `acc_valid` has no effect while the engine waits for the response.
- R4: A response with `rr_rsp_hit`=1 adds one to the score of the tested candidate. A miss leaves the score unchanged.
- R5: The phase best score and the phase best offset change only when an updated score is strictly greater than the phase best score. On a tie the earlier candidate stays.
- R6: After the last list entry is tested, the pointer returns to entry 0 and the round count increases by one.
- R7: At a round end where the phase best score is at least SCORE_MAX, the phase best offset becomes the active offset and prefetching is enabled. Round count, best score, phase best offset and all scores are cleared.
- R8: At a round end where the round count reaches ROUND_MAX, the phase ends in the same way as in R7, even when no score reached SCORE_MAX.
- R9: At a round end without a phase end, prefetching is disabled if the phase best score is at or below BAD_SCORE.
- R10: After reset, `acc_ready`=1, `pf_valid`=0 and `rr_req_valid`=0. The active offset is 1, prefetching is disabled, and all learning state is zero.
- R11: In the cycle after the response, `pf_valid` is high for one cycle exactly when prefetching is enabled after that access's update. `pf_addr` = access address + active offset × 2^LINE_BITS, with the offset sign-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Demand access offered |
| acc_ready | output | 1 | Engine can accept an access |
| acc_addr | input | ADDR_W | Demand access byte address |
| rr_req_valid | output | 1 | Recent-requests lookup strobe |
| rr_req_tag | output | TAG_W | Tag to look up (tag minus candidate) |
| rr_rsp_valid | input | 1 | Lookup answer present |
| rr_rsp_hit | input | 1 | Lookup answer: tag was seen recently |
| pf_valid | output | 1 | Prefetch request strobe |
| pf_addr | output | ADDR_W | Prefetch byte address |

## Verification
Two functions can fall in the same update cycle: a score increment on the last list entry, and the round-end decision that closes the phase. The bench provokes this by answering hits only for the final candidate. The third such hit lifts the best score to SCORE_MAX in the very response that wraps the round. It then checks that the prefetch emitted for that same access is already valid and uses the newly won offset, rather than the old one or none. A tie between two candidates is set up the same way, to check that the strictly-greater rule keeps the earlier offset when both reach the limit in one round.

// File: rtl/ole_pkg.sv
package ole_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOOKUP = 2'd1,
        ST_WAIT   = 2'd2,
        ST_EMIT   = 2'd3
    } ole_state_e;

    // Candidate offset at list position idx: positive 2/3/5-smooth numbers
    // in ascending order, optionally interleaved with their negations.
    function automatic int smooth_offset(input int idx, input bit neg);
        int pos;
        int seen;
        int cand;
        int rem;
        int res;
        pos  = neg ? (idx / 2) : idx;
        seen = 0;
        cand = 0;
        res  = 1;
        while (seen <= pos) begin
            cand = cand + 1;
            rem  = cand;
            while ((rem % 2) == 0) rem = rem / 2;
            while ((rem % 3) == 0) rem = rem / 3;
            while ((rem % 5) == 0) rem = rem / 5;
            if (rem == 1) begin
                if (seen == pos) res = cand;
                seen = seen + 1;
            end
        end
        return (neg && ((idx % 2) == 1)) ? -res : res;
    endfunction

endpackage

// File: rtl/ole_offset_table.sv
module ole_offset_table #(
    parameter int LIST_N = 16,
    parameter int OFF_W  = 8,
    parameter bit NEG_EN = 1'b0,
    localparam int IDX_W = (LIST_N > 1) ? $clog2(LIST_N) : 1
) (
    input  logic [IDX_W-1:0]        idx,
    output logic signed [OFF_W-1:0] sel_off
);

    logic signed [OFF_W-1:0] tab [LIST_N];

    for (genvar g = 0; g < LIST_N; g++) begin : g_ent
        localparam int VAL = ole_pkg::smooth_offset(g, NEG_EN);
        assign tab[g] = OFF_W'(VAL);
    end

    assign sel_off = tab[idx];

endmodule

// File: rtl/ole_score_bank.sv
module ole_score_bank #(
    parameter int LIST_N  = 16,
    parameter int SCORE_W = 5,
    localparam int IDX_W  = (LIST_N > 1) ? $clog2(LIST_N) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [IDX_W-1:0]   idx,
    input  logic               inc,
    input  logic               clr,
    output logic [SCORE_W-1:0] upd_score
);

    logic [SCORE_W-1:0] sc [LIST_N];
    logic [SCORE_W-1:0] cur;
    logic [SCORE_W-1:0] nxt;

    assign cur = sc[idx];
    assign nxt = (cur == {SCORE_W{1'b1}}) ? cur : cur + 1'b1;
    assign upd_score = inc ? nxt : cur;

    for (genvar g = 0; g < LIST_N; g++) begin : g_sc
        logic [SCORE_W-1:0] q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (clr) begin
                q <= '0;
            end else if (inc && (idx == IDX_W'(g))) begin
                q <= nxt;
            end
        end
        assign sc[g] = q;
    end

endmodule

// File: rtl/ole_phase_ctrl.sv
module ole_phase_ctrl #(
    parameter int LIST_N    = 16,
    parameter int OFF_W     = 8,
    parameter int SCORE_W   = 5,
    parameter int SCORE_MAX = 15,
    parameter int ROUND_MAX = 31,
    parameter int BAD_SCORE = 1,
    localparam int IDX_W    = (LIST_N > 1) ? $clog2(LIST_N) : 1,
    localparam int RND_W    = $clog2(ROUND_MAX + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    upd,
    input  logic                    hit,
    input  logic [SCORE_W-1:0]      upd_score,
    input  logic signed [OFF_W-1:0] cur_off,
    output logic [IDX_W-1:0]        ptr,
    output logic signed [OFF_W-1:0] active_off,
    output logic                    issue_en,
    output logic                    phase_end
);

    logic [SCORE_W-1:0]      best_sc;
    logic signed [OFF_W-1:0] phase_off;
    logic [RND_W-1:0]        round_q;

    logic [SCORE_W-1:0]      new_best;
    logic signed [OFF_W-1:0] new_poff;
    logic [RND_W-1:0]        rnd_inc;
    logic                    last;
    logic                    better;

    assign better   = hit && (upd_score > best_sc);
    assign new_best = better ? upd_score : best_sc;
    assign new_poff = better ? cur_off : phase_off;
    assign last     = (ptr == IDX_W'(LIST_N - 1));
    assign rnd_inc  = round_q + 1'b1;
    assign phase_end = upd && last &&
                       ((new_best >= SCORE_W'(SCORE_MAX)) ||
                        (rnd_inc == RND_W'(ROUND_MAX)));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr        <= '0;
            round_q    <= '0;
            best_sc    <= '0;
            phase_off  <= '0;
            active_off <= OFF_W'(1);
            issue_en   <= 1'b0;
        end else if (upd) begin
            if (last) begin
                ptr <= '0;
                if (phase_end) begin
                    active_off <= new_poff;
                    round_q    <= '0;
                    best_sc    <= '0;
                    phase_off  <= '0;
                    issue_en   <= 1'b1;
                end else begin
                    round_q   <= rnd_inc;
                    best_sc   <= new_best;
                    phase_off <= new_poff;
                    if (new_best <= SCORE_W'(BAD_SCORE)) begin
                        issue_en <= 1'b0;
                    end
                end
            end else begin
                ptr       <= ptr + 1'b1;
                best_sc   <= new_best;
                phase_off <= new_poff;
            end
        end
    end

endmodule

// File: rtl/offset_learn_engine.sv
module offset_learn_engine #(
    parameter int ADDR_W    = 32,
    parameter int LINE_BITS = 6,
    parameter int TAG_W     = 12,
    parameter int LIST_N    = 16,
    parameter int OFF_W     = 8,
    parameter bit NEG_EN    = 1'b0,
    parameter int SCORE_MAX = 15,
    parameter int ROUND_MAX = 31,
    parameter int BAD_SCORE = 1,
    localparam int IDX_W    = (LIST_N > 1) ? $clog2(LIST_N) : 1,
    localparam int LIM      = (SCORE_MAX > ROUND_MAX) ? SCORE_MAX : ROUND_MAX,
    localparam int SCORE_W  = $clog2(LIM + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    output logic              acc_ready,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              rr_req_valid,
    output logic [TAG_W-1:0]  rr_req_tag,
    input  logic              rr_rsp_valid,
    input  logic              rr_rsp_hit,
    output logic              pf_valid,
    output logic [ADDR_W-1:0] pf_addr
);
    import ole_pkg::*;

    ole_state_e state_q;
    ole_state_e state_d;

    logic [ADDR_W-1:0]       addr_q;
    logic [TAG_W-1:0]        tag_q;
    logic                    accept;
    logic                    upd;
    logic [IDX_W-1:0]        ptr;
    logic signed [OFF_W-1:0] sel_off;
    logic signed [OFF_W-1:0] active_off;
    logic [SCORE_W-1:0]      upd_score;
    logic                    issue_en;
    logic                    phase_end;

    assign accept = (state_q == ST_IDLE) && acc_valid;
    assign upd    = (state_q == ST_WAIT) && rr_rsp_valid;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (acc_valid)    state_d = ST_LOOKUP;
            ST_LOOKUP:                   state_d = ST_WAIT;
            ST_WAIT:   if (rr_rsp_valid) state_d = ST_EMIT;
            ST_EMIT:                     state_d = ST_IDLE;
            default:                     state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        acc_ready    = 1'b0;
        rr_req_valid = 1'b0;
        pf_valid     = 1'b0;
        unique case (state_q)
            ST_IDLE:   acc_ready    = 1'b1;
            ST_LOOKUP: rr_req_valid = 1'b1;
            ST_WAIT:   ;
            ST_EMIT:   pf_valid     = issue_en;
            default:   ;
        endcase
    end

    // Access capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            tag_q  <= '0;
        end else if (accept) begin
            addr_q <= acc_addr;
            tag_q  <= TAG_W'(acc_addr >> LINE_BITS);
        end
    end

    assign rr_req_tag = tag_q - TAG_W'(sel_off);
    assign pf_addr    = addr_q + (ADDR_W'(active_off) << LINE_BITS);

    ole_offset_table #(
        .LIST_N (LIST_N),
        .OFF_W  (OFF_W),
        .NEG_EN (NEG_EN)
    ) u_table (
        .idx     (ptr),
        .sel_off (sel_off)
    );

    ole_score_bank #(
        .LIST_N  (LIST_N),
        .SCORE_W (SCORE_W)
    ) u_scores (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx       (ptr),
        .inc       (upd && rr_rsp_hit),
        .clr       (phase_end),
        .upd_score (upd_score)
    );

    ole_phase_ctrl #(
        .LIST_N    (LIST_N),
        .OFF_W     (OFF_W),
        .SCORE_W   (SCORE_W),
        .SCORE_MAX (SCORE_MAX),
        .ROUND_MAX (ROUND_MAX),
        .BAD_SCORE (BAD_SCORE)
    ) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .upd        (upd),
        .hit        (rr_rsp_hit),
        .upd_score  (upd_score),
        .cur_off    (sel_off),
        .ptr        (ptr),
        .active_off (active_off),
        .issue_en   (issue_en),
        .phase_end  (phase_end)
    );

endmodule

// File: rtl/ole_checker.sv
module ole_checker (
    input logic clk,
    input logic rst_n,
    input logic acc_valid,
    input logic acc_ready,
    input logic rr_req_valid,
    input logic rr_rsp_valid,
    input logic pf_valid
);

    a_r3_accept_to_req: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_ready) |=> rr_req_valid);

    a_r3_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        rr_req_valid |=> !rr_req_valid);

    a_r3_busy_during_req: assert property (@(posedge clk) disable iff (!rst_n)
        rr_req_valid |-> !acc_ready);

    a_r3_no_accept_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        rr_req_valid |=> !acc_ready);

    a_r11_pf_single: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |=> !pf_valid);

    a_r11_pf_follows_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> $past(rr_rsp_valid));

    a_r11_pf_not_with_req: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> (!rr_req_valid && !acc_ready));

endmodule

bind offset_learn_engine ole_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_valid    (acc_valid),
    .acc_ready    (acc_ready),
    .rr_req_valid (rr_req_valid),
    .rr_rsp_valid (rr_rsp_valid),
    .pf_valid     (pf_valid)
);

// File: tb/offset_learn_engine_tb_top.sv
`timescale 1ns/1ps
module offset_learn_engine_tb_top;

    localparam int AW = 32;
    localparam int TW = 12;
    localparam int LN = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic a_valid = 1'b0;
    logic [AW-1:0] a_addr = '0;
    logic rsp_v = 1'b0;
    logic rsp_hit = 1'b0;
    bit   sel_neg = 1'b0;
    bit   done = 1'b0;

    logic p_ready, p_req, p_pf;
    logic [TW-1:0] p_tag;
    logic [AW-1:0] p_pfa;
    logic n_ready, n_req, n_pf;
    logic [TW-1:0] n_tag;
    logic [AW-1:0] n_pfa;

    logic o_ready, o_req, o_pf;
    logic [TW-1:0] o_tag;
    logic [AW-1:0] o_pfa;

    int n_chk = 0;
    int n_err = 0;

    // model of the learning state
    int m_sc [LN];
    int m_best, m_poff, m_round, m_act, m_ptr;
    bit m_issue;

    always #2.5 clk = ~clk;

    offset_learn_engine #(
        .ADDR_W(AW), .LINE_BITS(6), .TAG_W(TW), .LIST_N(LN), .OFF_W(8),
        .NEG_EN(1'b0), .SCORE_MAX(3), .ROUND_MAX(4), .BAD_SCORE(1)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(a_valid && !sel_neg), .acc_ready(p_ready), .acc_addr(a_addr),
        .rr_req_valid(p_req), .rr_req_tag(p_tag),
        .rr_rsp_valid(rsp_v && !sel_neg), .rr_rsp_hit(rsp_hit),
        .pf_valid(p_pf), .pf_addr(p_pfa)
    );

    offset_learn_engine #(
        .ADDR_W(AW), .LINE_BITS(6), .TAG_W(TW), .LIST_N(LN), .OFF_W(8),
        .NEG_EN(1'b1), .SCORE_MAX(3), .ROUND_MAX(4), .BAD_SCORE(1)
    ) dut_n_i (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(a_valid && sel_neg), .acc_ready(n_ready), .acc_addr(a_addr),
        .rr_req_valid(n_req), .rr_req_tag(n_tag),
        .rr_rsp_valid(rsp_v && sel_neg), .rr_rsp_hit(rsp_hit),
        .pf_valid(n_pf), .pf_addr(n_pfa)
    );

    assign o_ready = sel_neg ? n_ready : p_ready;
    assign o_req   = sel_neg ? n_req   : p_req;
    assign o_tag   = sel_neg ? n_tag   : p_tag;
    assign o_pf    = sel_neg ? n_pf    : p_pf;
    assign o_pfa   = sel_neg ? n_pfa   : p_pfa;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // R1: 1,2,3,4 or 1,-1,2,-2
    function automatic int off_of(input int i);
        if (sel_neg) return ((i % 2) == 1) ? -(i / 2 + 1) : (i / 2 + 1);
        return i + 1;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < LN; i++) m_sc[i] = 0;
        m_best = 0; m_poff = 0; m_round = 0; m_act = 1; m_ptr = 0; m_issue = 0;
    endtask

    task automatic model_update(input bit hit);
        if (hit) begin
            m_sc[m_ptr]++;
            if (m_sc[m_ptr] > m_best) begin
                m_best = m_sc[m_ptr];
                m_poff = off_of(m_ptr);
            end
        end
        if (m_ptr == LN - 1) begin
            m_ptr = 0;
            m_round++;
            if (m_best >= 3 || m_round == 4) begin
                m_act = m_poff;
                for (int i = 0; i < LN; i++) m_sc[i] = 0;
                m_best = 0; m_poff = 0; m_round = 0; m_issue = 1;
            end else if (m_best <= 1) begin
                m_issue = 0;
            end
        end else begin
            m_ptr++;
        end
    endtask

    task automatic do_reset(input bit neg);
        @(negedge clk);
        sel_neg = neg;
        rst_n = 1'b0;
        a_valid = 1'b0;
        rsp_v = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    // One access: accept, check lookup, answer after dly cycles, check prefetch.
    task automatic access(input logic [AW-1:0] a, input bit hit, input int dly);
        logic [TW-1:0] exp_tag;
        logic [AW-1:0] exp_pf;
        exp_tag = TW'(a >> 6) - TW'(off_of(m_ptr));
        chk(o_ready == 1'b1, "R3", "ready in idle", o_ready, 1);
        a_addr = a;
        a_valid = 1'b1;
        @(negedge clk);
        a_valid = 1'b0;
        chk(o_req == 1'b1, "R3", "lookup strobe", o_req, 1);
        chk(o_tag == exp_tag, "R2", "lookup tag", o_tag, exp_tag);
        chk(o_ready == 1'b0, "R3", "busy in lookup", o_ready, 0);
        @(negedge clk);
        for (int k = 0; k < dly; k++) begin
            a_valid = 1'b1;
            a_addr = a ^ 32'h0000_5A40;
            chk(!o_ready && !o_req, "R3", "quiet while waiting",
                {o_ready, o_req}, 0);
            @(negedge clk);
        end
        a_valid = 1'b0;
        rsp_v = 1'b1;
        rsp_hit = hit;
        @(negedge clk);
        rsp_v = 1'b0;
        rsp_hit = 1'b0;
        model_update(hit);
        exp_pf = a + AW'(m_act * 64);
        chk(o_pf == m_issue, "R11", "pf_valid", o_pf, m_issue);
        if (m_issue) chk(o_pfa == exp_pf, "R11", "pf_addr", o_pfa, exp_pf);
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset(1'b0);
        chk(o_ready == 1'b1, "R10", "ready after reset", o_ready, 1);
        chk(o_pf == 1'b0, "R10", "pf after reset", o_pf, 0);
        chk(o_req == 1'b0, "R10", "req after reset", o_req, 0);
    endtask

    // R1 R2 R4 R10: miss-only round, every tag checked, no prefetch
    task automatic t_first_round();
        do_reset(1'b0);
        for (int i = 0; i < LN; i++) access(32'h1234_0000 + AW'(i * 448), 1'b0, i);
        chk(m_round == 1, "R6", "round count model", m_round, 1);
        // R2: tag field wraps below zero, high address bits discarded
        access(32'hFFFC_0000, 1'b0, 0);
    endtask

    // R7: third hit on the last entry closes the phase in the same update
    task automatic t_score_max();
        do_reset(1'b0);
        for (int r = 0; r < 3; r++)
            for (int i = 0; i < LN; i++)
                access(32'h2000_0000 + AW'((r * 4 + i) * 64), i == 3, (i + r) % 3);
        chk(m_act == 4 && m_issue, "R7", "phase won by offset 4", m_act, 4);
        access(32'h2100_0000, 1'b0, 1);
    endtask

    // R5: offsets 2 and 3 tie at the limit, earlier one wins
    task automatic t_tie();
        do_reset(1'b0);
        for (int r = 0; r < 3; r++)
            for (int i = 0; i < LN; i++)
                access(32'h3000_0000 + AW'((r * 4 + i) * 64), (i == 1) || (i == 2), 0);
        chk(m_act == 2, "R5", "tie keeps earlier", m_act, 2);
        access(32'h3100_0040, 1'b1, 2);
    endtask

    // R8 then R9: round-limit phase end, then a poor round disables issue
    task automatic t_round_max_and_bad();
        do_reset(1'b0);
        for (int r = 0; r < 4; r++)
            for (int i = 0; i < LN; i++)
                access(32'h4000_0000 + AW'((r * 4 + i) * 64), (i == 2) && (r < 2), 0);
        chk(m_act == 3 && m_issue, "R8", "round limit phase end", m_act, 3);
        for (int i = 0; i < LN; i++) access(32'h4100_0000 + AW'(i * 64), 1'b0, 1);
        chk(!m_issue, "R9", "bad round disables", m_issue, 0);
        access(32'h4200_0000, 1'b0, 0);
    endtask

    // R1 with negatives: winner is -1, prefetch goes one line down
    task automatic t_negative();
        do_reset(1'b1);
        for (int r = 0; r < 3; r++)
            for (int i = 0; i < LN; i++)
                access(32'h5000_0800 + AW'((r * 4 + i) * 64), i == 1, r);
        chk(m_act == -1, "R1", "negative winner", m_act, -1);
        access(32'h5100_0000, 1'b0, 0);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_first_round();
        t_score_max();
        t_tie();
        t_round_max_and_bad();
        t_negative();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule